// File: doc/BRIEF.md
# Scoreboard Dynamic Issue Controller

This block is the control half of a scoreboard that lets instructions finish out of program order. Decoded instructions arrive one at a time. Each names a functional unit class, an operation code, a destination register and two source registers. The controller grants each instruction four steps in turn: issue, operand read, execution start and result writeback. It is built from two tables. The unit status table has one entry per functional unit. The register result table records, for each architectural register, which unit will write it next.

Issue is in program order and handles at most one instruction per cycle. An instruction issues only when its unit is free and no unit in flight targets the same destination. Otherwise `in_ready` stays low and the whole stream waits. After issue, an instruction waits in its unit until neither source is owed by another unit. It is then granted its operand read and starts execution on the following cycle. An external pulse marks the end of execution. The result is written back when no other instruction still has to read the old value of the destination. If several units are eligible, the lowest-numbered one wins. Operand storage and the arithmetic itself lie outside this block.

Unit numbering: 0 integer, 1 FP add, 2 FP multiply, 3 FP divide. Bit u of every per-unit vector belongs to unit u.

Top module: `scoreboard_issue_ctl`

## Requirements
- R1: After reset every unit is idle. `read_grant`, `exec_start` and `wb_grant` are zero, and `in_ready` is high for any instruction.
- R2: `in_ready` is high exactly when the unit selected by `in_unit` is idle and no pending writer exists for `in_dst`. A clock edge with `in_valid` and `in_ready` both high issues the instruction. A request to a busy unit leaves `in_ready` low.
- R3: While any unit in flight has destination equal to `in_dst`, `in_ready` is low. At no time do two busy units hold the same destination.
- R4: A unit that is waiting for operands raises its `read_grant` bit in the first cycle in which neither source has a pending writer. A source owed by a producer becomes available in the cycle after that producer's writeback grant.
- R5: `exec_start[u]` pulses in the cycle after `read_grant[u]`. During that pulse, `start_op[u*OPW +: OPW]` carries the operation code that was issued to unit u.
- R6: `exec_done[u]` moves unit u to its writeback request only while u is executing. A pulse in any other phase has no effect.
- R7: Writeback of unit u is withheld while another unit that has not yet read its operands holds an available source register equal to u's destination.
- R8: At most one `wb_grant` bit is high per cycle. It goes to the lowest-numbered unit that requests writeback and is not withheld by R7.
- R9: A writeback grant frees the unit and clears the register's pending writer at that edge. A unit that issues in the same cycle with that register as a source treats it as available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decoded instruction present |
| in_unit | input | $clog2(NUNIT) | Target unit (0 int, 1 add, 2 mul, 3 div) |
| in_op | input | OPW | Operation code |
| in_dst | input | $clog2(NREG) | Destination register |
| in_src1 | input | $clog2(NREG) | First source register |
| in_src2 | input | $clog2(NREG) | Second source register |
| exec_done | input | NUNIT | Per-unit end-of-execution pulse |
| in_ready | output | 1 | Instruction can issue this cycle |
| read_grant | output | NUNIT | Per-unit operand read grant |
| exec_start | output | NUNIT | Per-unit execution start pulse |
| start_op | output | NUNIT*OPW | Stored operation code of each unit |
| wb_grant | output | NUNIT | Per-unit writeback grant |

## Verification
The bench sweeps every pair of destination registers to check the output-dependency stall. A design that compares the wrong field would either let two writers hold one register or stall on unrelated registers. It runs the classic anti-dependency sequence: a divide that waits on a multiply keeps an adder from overwriting a register the divide has not yet read. A design without the hold would grant the adder's writeback early, and a design with a fixed priority would also block the multiply behind the adder. Further cases cover a consumer that issues in the very cycle its producer writes back, which a design without the bypass would strand forever. They also cover an end-of-execution pulse sent to a unit still waiting for operands, which a careless design would turn into a writeback that skips the operand read.

// File: rtl/scoreboard_issue_ctl.sv
module scoreboard_issue_ctl #(
  parameter int NUNIT = 4,
  parameter int NREG  = 8,
  parameter int OPW   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [$clog2(NUNIT)-1:0] in_unit,
  input  logic [OPW-1:0]           in_op,
  input  logic [$clog2(NREG)-1:0]  in_dst,
  input  logic [$clog2(NREG)-1:0]  in_src1,
  input  logic [$clog2(NREG)-1:0]  in_src2,
  input  logic [NUNIT-1:0]         exec_done,
  output logic                     in_ready,
  output logic [NUNIT-1:0]         read_grant,
  output logic [NUNIT-1:0]         exec_start,
  output logic [NUNIT*OPW-1:0]     start_op,
  output logic [NUNIT-1:0]         wb_grant
);
  localparam int UW = $clog2(NUNIT);
  localparam int RW = $clog2(NREG);
  localparam int TW = $clog2(NUNIT + 1);
  localparam logic [1:0] P_IDLE = 2'd0, P_RD = 2'd1, P_EX = 2'd2, P_WB = 2'd3;

  logic [1:0]    phase [NUNIT];
  logic [OPW-1:0] op_q [NUNIT];
  logic [RW-1:0] dst_q [NUNIT];
  logic [RW-1:0] s1_q  [NUNIT];
  logic [RW-1:0] s2_q  [NUNIT];
  logic [TW-1:0] t1_q  [NUNIT];
  logic [TW-1:0] t2_q  [NUNIT];
  logic          r1_q  [NUNIT];
  logic          r2_q  [NUNIT];
  logic [TW-1:0] rstat [NREG];

  logic [NUNIT-1:0] war, wb_req;
  logic [UW-1:0]    wb_idx;
  logic             wb_any, issue;
  logic [TW-1:0]    wb_tag, cap_t1, cap_t2;

  assign in_ready = (phase[in_unit] == P_IDLE) && (rstat[in_dst] == '0);
  assign issue    = in_valid && in_ready;
  assign wb_grant = wb_req & (~wb_req + NUNIT'(1));
  assign wb_any   = |wb_req;
  assign wb_tag   = TW'(wb_idx) + TW'(1);
  assign cap_t1   = (wb_any && rstat[in_src1] == wb_tag) ? '0 : rstat[in_src1];
  assign cap_t2   = (wb_any && rstat[in_src2] == wb_tag) ? '0 : rstat[in_src2];

  always_comb begin
    for (int u = 0; u < NUNIT; u++) begin
      read_grant[u] = (phase[u] == P_RD) && r1_q[u] && r2_q[u];
      war[u] = 1'b0;
      for (int g = 0; g < NUNIT; g++)
        if (g != u && phase[g] == P_RD &&
            ((r1_q[g] && s1_q[g] == dst_q[u]) || (r2_q[g] && s2_q[g] == dst_q[u])))
          war[u] = 1'b1;
      wb_req[u] = (phase[u] == P_WB) && !war[u];
      start_op[u*OPW +: OPW] = op_q[u];
    end
    wb_idx = '0;
    for (int u = NUNIT - 1; u >= 0; u--)
      if (wb_req[u]) wb_idx = UW'(u);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exec_start <= '0;
      for (int r = 0; r < NREG; r++) rstat[r] <= '0;
      for (int u = 0; u < NUNIT; u++) begin
        phase[u] <= P_IDLE;
        op_q[u]  <= '0;
        dst_q[u] <= '0;
        s1_q[u]  <= '0;
        s2_q[u]  <= '0;
        t1_q[u]  <= '0;
        t2_q[u]  <= '0;
        r1_q[u]  <= 1'b0;
        r2_q[u]  <= 1'b0;
      end
    end else begin
      exec_start <= read_grant;
      if (wb_any) rstat[dst_q[wb_idx]] <= '0;
      if (issue)  rstat[in_dst] <= TW'(in_unit) + TW'(1);
      for (int u = 0; u < NUNIT; u++) begin
        case (phase[u])
          P_IDLE: if (issue && in_unit == UW'(u)) begin
            phase[u] <= P_RD;
            op_q[u]  <= in_op;
            dst_q[u] <= in_dst;
            s1_q[u]  <= in_src1;
            s2_q[u]  <= in_src2;
            t1_q[u]  <= cap_t1;
            t2_q[u]  <= cap_t2;
            r1_q[u]  <= (cap_t1 == '0);
            r2_q[u]  <= (cap_t2 == '0);
          end
          P_RD: begin
            if (wb_any && t1_q[u] == wb_tag) begin
              t1_q[u] <= '0;
              r1_q[u] <= 1'b1;
            end
            if (wb_any && t2_q[u] == wb_tag) begin
              t2_q[u] <= '0;
              r2_q[u] <= 1'b1;
            end
            if (read_grant[u]) phase[u] <= P_EX;
          end
          P_EX: if (exec_done[u]) phase[u] <= P_WB;
          default: if (wb_grant[u]) phase[u] <= P_IDLE;
        endcase
      end
    end
  end

  assert_wb_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wb_grant));

  for (genvar u = 0; u < NUNIT; u++) begin : g_chk
    assert_issue_enters_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_unit == UW'(u)) |=> phase[u] == P_RD);
    assert_start_in_exec_R5: assert property (@(posedge clk) disable iff (!rst_n)
      exec_start[u] |-> phase[u] == P_EX);
    assert_wb_frees_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wb_grant[u] |=> (phase[u] == P_IDLE && rstat[dst_q[u]] == '0));
    for (genvar g = u + 1; g < NUNIT; g++) begin : g_pair
      assert_single_writer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase[u] != P_IDLE && phase[g] != P_IDLE) |-> dst_q[u] != dst_q[g]);
    end
  end
endmodule

// File: tb/scoreboard_issue_ctl_tb_top.sv
module scoreboard_issue_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int OPW = 4;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [1:0] in_unit = 0;
  logic [OPW-1:0] in_op = 0;
  logic [2:0] in_dst = 0, in_src1 = 0, in_src2 = 0;
  logic [3:0] exec_done = 0;
  logic in_ready;
  logic [3:0] read_grant, exec_start, wb_grant;
  logic [4*OPW-1:0] start_op;
  int checks = 0, failures = 0;
  bit finished = 0;

  scoreboard_issue_ctl #(.NUNIT(4), .NREG(8), .OPW(OPW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_unit(in_unit), .in_op(in_op),
    .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2), .exec_done(exec_done),
    .in_ready(in_ready), .read_grant(read_grant), .exec_start(exec_start),
    .start_op(start_op), .wb_grant(wb_grant));

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic present(input int u, input int op, input int d, input int a, input int b,
                         input bit v);
    in_unit = 2'(u); in_op = OPW'(op); in_dst = 3'(d);
    in_src1 = 3'(a); in_src2 = 3'(b); in_valid = v;
    #1;
  endtask

  task automatic drain();
    in_valid = 0;
    repeat (9) begin exec_done = 4'hF; step(); end
    exec_done = 0;
    step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    present(0, 0, 0, 0, 0, 0);
    chk("R1 in_ready", in_ready, 1);
    chk("R1 read_grant", read_grant, 0);
    chk("R1 exec_start", exec_start, 0);
    chk("R1 wb_grant", wb_grant, 0);

    // basic flow through every unit
    for (int u = 0; u < 4; u++) begin
      present(u, u + 5, 1, 2, 3, 1);
      chk("R2 ready idle", in_ready, 1);
      step();
      in_valid = 0; #1;
      chk("R4 read grant", read_grant, 1 << u);
      step(); #1;
      chk("R5 exec start", exec_start, 1 << u);
      chk("R5 start op", int'(start_op[u*OPW +: OPW]), u + 5);
      chk("R5 read one cycle", read_grant, 0);
      exec_done = 4'(1 << u); #1;
      chk("R6 no wb yet", wb_grant, 0);
      step();
      exec_done = 0; #1;
      chk("R6 wb request", wb_grant, 1 << u);
      step(); #1;
      chk("R9 wb once", wb_grant, 0);
      chk("R9 unit freed", in_ready, 1);
    end

    // invalid input issues nothing
    present(1, 0, 2, 0, 0, 0);
    step(); #1;
    chk("R2 no issue without valid", read_grant, 0);

    // structural stall
    present(2, 1, 1, 0, 0, 1);
    step();
    present(2, 1, 3, 0, 0, 1);
    chk("R2 busy unit stalls", in_ready, 0);
    present(3, 1, 3, 0, 0, 1);
    chk("R2 other unit free", in_ready, 1);
    step();
    drain();

    // output dependency with release
    present(0, 2, 5, 0, 0, 1);
    step();
    present(1, 2, 5, 0, 0, 1);
    chk("R3 same dest stalls", in_ready, 0);
    step();
    exec_done = 4'b0001; #1;
    chk("R3 still stalled", in_ready, 0);
    step();
    exec_done = 0; #1;
    chk("R3 producer writes", wb_grant, 1);
    chk("R3 stall during wb", in_ready, 0);
    step(); #1;
    chk("R3 released", in_ready, 1);
    step();
    in_valid = 0; #1;
    chk("R3 second writer reads", read_grant, 4'b0010);
    drain();

    // destination pair sweep
    for (int d1 = 0; d1 < 8; d1++)
      for (int d2 = 0; d2 < 8; d2++) begin
        present(0, 0, d1, 0, 0, 1);
        step();
        present(1, 0, d2, 0, 0, 0);
        chk("R3 sweep", in_ready, (d1 != d2) ? 1 : 0);
        drain();
      end

    // true dependency wakeup
    present(2, 3, 4, 0, 0, 1);
    step();
    present(1, 3, 6, 4, 0, 1);
    chk("R4 consumer issues", in_ready, 1);
    step();
    in_valid = 0; #1;
    chk("R4 consumer waits", read_grant, 0);
    exec_done = 4'b0100;
    step();
    exec_done = 0; #1;
    chk("R4 producer wb", wb_grant, 4'b0100);
    chk("R4 still waiting", read_grant, 0);
    step(); #1;
    chk("R4 wakeup", read_grant, 4'b0010);
    drain();

    // anti-dependency hold
    present(2, 1, 2, 1, 3, 1);
    step();
    present(3, 2, 0, 2, 4, 1);
    chk("R4 mul reads", read_grant, 4'b0100);
    step();
    present(1, 3, 4, 6, 7, 1);
    chk("R7 add issues", in_ready, 1);
    chk("R4 div waits", read_grant, 0);
    step();
    in_valid = 0; #1;
    chk("R4 add reads", read_grant, 4'b0010);
    step();
    exec_done = 4'b0010; #1;
    step();
    exec_done = 4'b1100; #1;
    chk("R7 add held", wb_grant, 0);
    step();
    exec_done = 0; #1;
    chk("R8 mul passes held add", wb_grant, 4'b0100);
    chk("R6 div unaffected", read_grant, 0);
    step(); #1;
    chk("R4 div reads", read_grant, 4'b1000);
    chk("R7 add still held", wb_grant, 0);
    step(); #1;
    chk("R7 add released", wb_grant, 4'b0010);
    chk("R5 div starts", exec_start, 4'b1000);
    chk("R5 div op", int'(start_op[3*OPW +: OPW]), 2);
    drain();

    // priority
    present(2, 0, 1, 0, 0, 1);
    step();
    present(0, 0, 2, 0, 0, 1);
    step();
    in_valid = 0; #1;
    chk("R8 int reads", read_grant, 4'b0001);
    step();
    exec_done = 4'b0101; #1;
    step();
    exec_done = 0; #1;
    chk("R8 lowest first", wb_grant, 4'b0001);
    step(); #1;
    chk("R8 next unit", wb_grant, 4'b0100);
    step(); #1;
    chk("R8 none left", wb_grant, 0);

    // same-cycle bypass
    present(0, 0, 3, 0, 0, 1);
    step();
    in_valid = 0;
    step();
    exec_done = 4'b0001;
    step();
    exec_done = 0;
    present(1, 0, 5, 3, 4, 1);
    chk("R9 producer wb", wb_grant, 4'b0001);
    chk("R9 consumer accepted", in_ready, 1);
    step();
    in_valid = 0; #1;
    chk("R9 bypass ready", read_grant, 4'b0010);
    drain();

    // done pulse to idle units
    exec_done = 4'hF;
    step();
    exec_done = 0; #1;
    chk("R6 idle done ignored", wb_grant, 0);
    chk("R6 idle no read", read_grant, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule